// File: doc/BRIEF.md
# Secure System Counter

This block keeps a 64-bit timestamp for a chip and shows it through a small set of 32-bit registers. It has a control word, a read-only status word, the count as a low and a high word, and a frequency word. Software reads the frequency word to learn the tick rate and can also write it. A run bit in the control word starts the count and stops it. When the count is stopped it keeps its value, and it carries on from that value when started again. The count advances once on each clock cycle in which the run bit is set and the tick strobe is high.

Reads are served whatever the security attribute of the request. A write takes effect only when its secure attribute is high. A write with the attribute low changes nothing and gets an error response. Every request gets exactly one response, one cycle later. Reading the low count word also saves the upper half of the count into a snapshot. The next read of the high word returns that snapshot, so a 64-bit value read as two words always belongs together.

Top module: `secure_sys_counter`

## Requirements
- R1: After reset the control word, the count, the frequency word and the snapshot are all zero, and `rsp_valid` is low.
- R2: The control word is at byte offset 0x00. Bit 0 is the run bit and bit 1 is a stored halt-request bit with no other effect. Bits 31:2 read as zero.
- R3: The status word is at byte offset 0x04. It always reads zero, because bit 1, the halted flag, is never set. A secure write to it is accepted and has no effect.
- R4: While the run bit is set, the count rises by exactly one on each cycle in which `tick_en` is high. On every other cycle it does not move.
- R5: Clearing the run bit freezes the count. Setting the run bit again resumes counting from the frozen value.
- R6: A read of the low word at 0x08 returns bits 31:0 of the count as it was before the request edge, and it saves bits 63:32 of that count. A read of the high word at 0x0C returns the saved value.
- R7: A write with `req_secure` low gets a response with `rsp_err` high and changes no register.
- R8: A legal write with `req_secure` high gets a response with `rsp_err` low. Secure writes to 0x08 and 0x0C are accepted but leave the count unchanged.
- R9: A legal read returns `rsp_err` low whatever the value of `req_secure`.
- R10: An access is legal only when all three of these hold: `req_size` is 2'b10 (a 32-bit word), the byte address is a multiple of 4, and the address is at most 0x20. Any other access, read or write, gets `rsp_err` high, changes nothing and returns read data zero.
- R11: A legal read of an unassigned word (0x10, 0x14, 0x18, 0x1C) returns zero with `rsp_err` low. A secure write to such a word is accepted and changes nothing.
- R12: Each cycle that has `req_valid` high leads to exactly one cycle with `rsp_valid` high, on the next clock cycle. `rsp_valid` is never high at any other time.
- R13: The frequency word at 0x20 holds all 32 bits written by a secure write and returns them on a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Count strobe; the count advances on cycles where this is high |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | Security attribute of the request |
| req_addr | input | ADDR_W (6) | Byte address inside the block |
| req_size | input | 2 | Access size; 2'b10 = 32-bit word |
| req_wdata | input | 32 | Write data, little-endian word |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Error response |
| rsp_rdata | output | 32 | Read data; zero for writes and errors |

## Verification
The checker watches every cycle for the things that hold without regard to history. It checks that the count steps by exactly one when its run condition is true and holds otherwise. It checks that refused writes answer with an error and leave the run bit alone. It also checks that every request gets its response on the next cycle, that legal reads never error, and that a bad size always errors. Other behaviours depend on a sequence of accesses, and only the bench's scenarios can show them. These include resuming from a frozen value, the snapshot pairing of the low and high reads, writes to the count and status words having no effect, and what reads return. The bench covers them with a reference model that predicts every response cycle by cycle.

// File: rtl/scnt_pkg.sv
package scnt_pkg;

  localparam int unsigned WORD_W     = 32;
  localparam int unsigned CTRL_KEEP  = 2;
  localparam int unsigned WINDOW_TOP = 32'h20;
  localparam logic [1:0]  SIZE_WORD  = 2'b10;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_CTRL = 3'd1,
    SEL_STAT = 3'd2,
    SEL_CLO  = 3'd3,
    SEL_CHI  = 3'd4,
    SEL_FREQ = 3'd5
  } reg_sel_e;

  // legal = full word, aligned, inside the register window
  function automatic logic f_access_legal(input logic [31:0] byte_ofs,
                                          input logic [1:0]  size);
    return (size == SIZE_WORD) && (byte_ofs[1:0] == 2'b00) &&
           (byte_ofs <= WINDOW_TOP);
  endfunction

  function automatic reg_sel_e f_pick_reg(input logic [31:0] byte_ofs);
    case (byte_ofs)
      32'h00:  return SEL_CTRL;
      32'h04:  return SEL_STAT;
      32'h08:  return SEL_CLO;
      32'h0C:  return SEL_CHI;
      32'h20:  return SEL_FREQ;
      default: return SEL_NONE;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] f_ctrl_view(input logic [CTRL_KEEP-1:0] kept);
    return {{(WORD_W-CTRL_KEEP){1'b0}}, kept};
  endfunction

  function automatic logic [WORD_W-1:0] f_status_view(input logic halted);
    return {{(WORD_W-2){1'b0}}, halted, 1'b0};
  endfunction

endpackage

// File: rtl/scnt_decode.sv
module scnt_decode
  import scnt_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  output reg_sel_e          sel,
  output logic              legal
);

  logic [31:0] byte_ofs;

  always_comb begin
    byte_ofs = 32'(req_addr);
    legal    = f_access_legal(byte_ofs, req_size);
    sel      = legal ? f_pick_reg(byte_ofs) : SEL_NONE;
  end

endmodule

// File: rtl/scnt_gate.sv
module scnt_gate (
  input  logic req_valid,
  input  logic req_write,
  input  logic req_secure,
  input  logic legal,
  output logic wr_take,
  output logic wr_refuse,
  output logic rd_take,
  output logic err_next
);

  always_comb begin
    wr_take   = req_valid &  req_write & req_secure & legal;
    wr_refuse = req_valid &  req_write & ~(req_secure & legal);
    rd_take   = req_valid & ~req_write & legal;
    err_next  = wr_refuse | (req_valid & ~req_write & ~legal);
  end

endmodule

// File: rtl/scnt_counter.sv
module scnt_counter #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  output logic [CNT_W-1:0] count_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count_q <= '0;
    else if (run) count_q <= count_q + CNT_W'(1);
  end

endmodule

// File: rtl/scnt_regs.sv
module scnt_regs
  import scnt_pkg::*;
#(
  parameter int unsigned CNT_W = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 wr_take,
  input  logic                 rd_take,
  input  logic                 err_next,
  input  reg_sel_e             sel,
  input  logic [WORD_W-1:0]    wdata,
  input  logic [CNT_W-1:0]     count,
  output logic [CTRL_KEEP-1:0] ctrl_q,
  output logic                 rsp_valid,
  output logic                 rsp_err,
  output logic [WORD_W-1:0]    rsp_rdata
);

  localparam int unsigned HI_W = CNT_W - WORD_W;

  logic [WORD_W-1:0] freq_q;
  logic [HI_W-1:0]   snap_q;
  logic [WORD_W-1:0] rd_word;
  logic              snap_load;

  assign snap_load = rd_take && (sel == SEL_CLO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      freq_q <= '0;
    end else if (wr_take) begin
      if (sel == SEL_CTRL) ctrl_q <= wdata[CTRL_KEEP-1:0];
      if (sel == SEL_FREQ) freq_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         snap_q <= '0;
    else if (snap_load) snap_q <= count[CNT_W-1:WORD_W];
  end

  always_comb begin
    case (sel)
      SEL_CTRL: rd_word = f_ctrl_view(ctrl_q);
      SEL_STAT: rd_word = f_status_view(1'b0);
      SEL_CLO:  rd_word = count[WORD_W-1:0];
      SEL_CHI:  rd_word = WORD_W'(snap_q);
      SEL_FREQ: rd_word = freq_q;
      default:  rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= err_next;
      rsp_rdata <= rd_take ? rd_word : '0;
    end
  end

endmodule

// File: rtl/secure_sys_counter.sv
module secure_sys_counter
  import scnt_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_secure,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata
);

  localparam int unsigned CNT_W = 2 * WORD_W;

  reg_sel_e             sel_w;
  logic                 legal_w;
  logic                 write_accepted;
  logic                 write_refused;
  logic                 read_served;
  logic                 err_next_w;
  logic [CTRL_KEEP-1:0] ctrl_w;
  logic                 ctrl_en_w;
  logic                 count_run;
  logic [CNT_W-1:0]     count_w;

  scnt_decode #(.ADDR_W(ADDR_W)) u_decode (
    .req_addr (req_addr),
    .req_size (req_size),
    .sel      (sel_w),
    .legal    (legal_w)
  );

  scnt_gate u_gate (
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_secure (req_secure),
    .legal      (legal_w),
    .wr_take    (write_accepted),
    .wr_refuse  (write_refused),
    .rd_take    (read_served),
    .err_next   (err_next_w)
  );

  assign ctrl_en_w = ctrl_w[0];
  assign count_run = ctrl_en_w & tick_en;

  scnt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (count_run),
    .count_q (count_w)
  );

  scnt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .wr_take   (write_accepted),
    .rd_take   (read_served),
    .err_next  (err_next_w),
    .sel       (sel_w),
    .wdata     (req_wdata),
    .count     (count_w),
    .ctrl_q    (ctrl_w),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata)
  );

endmodule

// File: rtl/scnt_checker.sv
module scnt_checker #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned CNT_W  = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic              req_secure,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_size,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic              count_run,
  input logic              ctrl_en_w,
  input logic              write_refused,
  input logic [CNT_W-1:0]  count_w
);

  logic insecure_wr;
  logic clean_rd;
  assign insecure_wr = req_valid && req_write && !req_secure;
  assign clean_rd    = req_valid && !req_write && (req_size == 2'b10) &&
                       (req_addr[1:0] == 2'b00) && (32'(req_addr) <= 32'h20);

  assert_step_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    count_run |=> count_w == $past(count_w) + CNT_W'(1));

  assert_hold_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !count_run |=> $stable(count_w));

  assert_insecure_errs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    insecure_wr |=> rsp_valid && rsp_err);

  assert_insecure_keeps_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    write_refused |=> $stable(ctrl_en_w));

  assert_read_ok_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clean_rd |=> rsp_valid && !rsp_err);

  assert_bad_size_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size != 2'b10) |=> rsp_err);

  assert_rsp_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_no_stray_rsp_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

endmodule

bind secure_sys_counter scnt_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_write     (req_write),
  .req_secure    (req_secure),
  .req_addr      (req_addr),
  .req_size      (req_size),
  .rsp_valid     (rsp_valid),
  .rsp_err       (rsp_err),
  .count_run     (count_run),
  .ctrl_en_w     (ctrl_en_w),
  .write_refused (write_refused),
  .count_w       (count_w)
);

// File: tb/secure_sys_counter_bench.sv
`timescale 1ns/1ps
module secure_sys_counter_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en;
  logic        req_valid, req_write, req_secure;
  logic [5:0]  req_addr;
  logic [1:0]  req_size;
  logic [31:0] req_wdata;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;

  always #2.5 clk = ~clk;

  secure_sys_counter u_secure_sys_counter (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .req_valid(req_valid), .req_write(req_write), .req_secure(req_secure),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [63:0] m_cnt;
  bit          m_run, m_halt;
  logic [31:0] m_freq, m_snap;
  bit          live = 0;
  bit          e_valid, e_err;
  logic [31:0] e_data;
  string       e_tag = "R12";

  always @(posedge clk) begin : model
    int unsigned a;
    bit good, was_run;
    if (!rst_n) begin
      m_cnt = '0; m_run = 0; m_halt = 0; m_freq = '0; m_snap = '0;
      e_valid = 0; e_err = 0; e_data = '0; live = 0;
    end else begin
      live    = 1;
      a       = req_addr;
      good    = (req_size == 2'b10) && (a % 4 == 0) && (a <= 32);
      was_run = m_run;
      e_valid = req_valid; e_err = 0; e_data = '0; e_tag = "R12";
      if (req_valid) begin
        if (!good) begin
          e_err = 1; e_tag = "R10";
        end else if (req_write) begin
          if (!req_secure) begin
            e_err = 1; e_tag = "R7";
          end else begin
            e_tag = "R8";
            if (a == 0)  begin m_run = req_wdata[0]; m_halt = req_wdata[1]; end
            if (a == 32) m_freq = req_wdata;
          end
        end else begin
          e_tag = "R9";
          case (a)
            0:  e_data = {30'd0, m_halt, was_run};
            8:  begin e_data = m_cnt[31:0]; m_snap = m_cnt[63:32]; end
            12: e_data = m_snap;
            32: e_data = m_freq;
            default: e_data = '0;
          endcase
        end
      end
      if (was_run && tick_en) m_cnt = m_cnt + 64'd1;
    end
  end

  always @(negedge clk) begin
    if (live) begin
      chk(rsp_valid == e_valid, "R12 rsp_valid", 32'(rsp_valid), 32'(e_valid));
      if (e_valid) begin
        chk(rsp_err == e_err, {e_tag, " rsp_err"}, 32'(rsp_err), 32'(e_err));
        chk(rsp_rdata == e_data, {e_tag, " rsp_rdata"}, rsp_rdata, e_data);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic acc(input bit w, input bit sec, input logic [5:0] a,
                     input logic [1:0] sz, input logic [31:0] wd,
                     output logic err, output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1; req_write = w; req_secure = sec;
    req_addr = a; req_size = sz; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    err = rsp_err; rd = rsp_rdata;
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R12 watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic        e;
    logic [31:0] d, v1, v2;
    rst_n = 0; tick_en = 1; req_valid = 0; req_write = 0; req_secure = 0;
    req_addr = '0; req_size = 2'b10; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk(rsp_valid == 0, "R1 rsp_valid in reset", 32'(rsp_valid), 0);
    rst_n = 1;

    acc(0, 1, 6'h00, 2'b10, 0, e, d); chk(d == 0, "R1 control", d, 0);
    acc(0, 1, 6'h08, 2'b10, 0, e, d); chk(d == 0, "R1 count low", d, 0);
    acc(0, 1, 6'h0C, 2'b10, 0, e, d); chk(d == 0, "R1 count high", d, 0);
    acc(0, 1, 6'h20, 2'b10, 0, e, d); chk(d == 0, "R1 freq", d, 0);

    acc(1, 1, 6'h20, 2'b10, 32'hA5C3_0F96, e, d); chk(e == 0, "R8 secure write ok", 32'(e), 0);
    acc(0, 1, 6'h20, 2'b10, 0, e, d); chk(d == 32'hA5C3_0F96, "R13 freq readback", d, 32'hA5C3_0F96);
    acc(1, 0, 6'h20, 2'b10, 32'h1, e, d); chk(e == 1, "R7 insecure err", 32'(e), 1);
    acc(0, 0, 6'h20, 2'b10, 0, e, d); chk(d == 32'hA5C3_0F96, "R7 freq kept", d, 32'hA5C3_0F96);
    chk(e == 0, "R9 insecure read ok", 32'(e), 0);

    acc(1, 1, 6'h00, 2'b10, 32'hFFFF_FFFF, e, d);
    acc(0, 1, 6'h00, 2'b10, 0, e, d); chk(d == 32'h3, "R2 control bits", d, 3);
    acc(1, 1, 6'h00, 2'b10, 32'h1, e, d);

    acc(0, 1, 6'h08, 2'b10, 0, e, v1);
    acc(0, 1, 6'h08, 2'b10, 0, e, v2); chk(v2 == v1 + 2, "R4 step per tick", v2, v1 + 2);
    acc(0, 1, 6'h0C, 2'b10, 0, e, d); chk(d == 0, "R6 high snapshot", d, 0);

    acc(1, 0, 6'h00, 2'b10, 0, e, d);
    acc(0, 1, 6'h08, 2'b10, 0, e, v1);
    acc(0, 1, 6'h08, 2'b10, 0, e, v2); chk(v2 == v1 + 2, "R7 still running", v2, v1 + 2);

    acc(1, 1, 6'h00, 2'b10, 0, e, d);
    acc(0, 1, 6'h08, 2'b10, 0, e, v1);
    repeat (6) @(negedge clk);
    acc(0, 1, 6'h08, 2'b10, 0, e, v2); chk(v2 == v1, "R5 frozen", v2, v1);
    acc(1, 1, 6'h00, 2'b10, 1, e, d);
    acc(0, 1, 6'h08, 2'b10, 0, e, v2); chk(v2 == v1 + 1, "R5 resume", v2, v1 + 1);

    tick_en = 0;
    acc(0, 1, 6'h08, 2'b10, 0, e, v1);
    acc(0, 1, 6'h08, 2'b10, 0, e, v2); chk(v2 == v1, "R4 no tick no step", v2, v1);
    tick_en = 1;

    acc(0, 1, 6'h08, 2'b10, 0, e, v1);
    acc(1, 1, 6'h08, 2'b10, 32'hFFFF_FFFF, e, d); chk(e == 0, "R8 count write ok", 32'(e), 0);
    acc(0, 1, 6'h08, 2'b10, 0, e, v2); chk(v2 == v1 + 4, "R8 count untouched", v2, v1 + 4);
    acc(1, 1, 6'h04, 2'b10, 32'hFFFF_FFFF, e, d);
    acc(0, 1, 6'h04, 2'b10, 0, e, d); chk(d == 0, "R3 status zero", d, 0);

    acc(0, 1, 6'h10, 2'b10, 0, e, d); chk(d == 0 && e == 0, "R11 hole read", d, 0);
    acc(1, 1, 6'h14, 2'b10, 32'h55, e, d); chk(e == 0, "R11 hole write", 32'(e), 0);

    acc(0, 1, 6'h24, 2'b10, 0, e, d); chk(e == 1, "R10 outside window", 32'(e), 1);
    acc(0, 1, 6'h20, 2'b00, 0, e, d); chk(e == 1, "R10 byte read", 32'(e), 1);
    acc(1, 1, 6'h20, 2'b01, 32'h0, e, d); chk(e == 1, "R10 half write", 32'(e), 1);
    acc(1, 1, 6'h22, 2'b10, 32'h0, e, d); chk(e == 1, "R10 misaligned", 32'(e), 1);
    acc(0, 1, 6'h20, 2'b10, 0, e, d); chk(d == 32'hA5C3_0F96, "R10 freq kept", d, 32'hA5C3_0F96);

    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      tick_en    = ($urandom % 4) != 0;
      req_valid  = ($urandom % 2) != 0;
      req_write  = ($urandom % 3) == 0;
      req_secure = ($urandom % 4) != 0;
      req_addr   = 6'($urandom % 11) << 2;
      if (($urandom % 16) == 0) req_addr = 6'($urandom);
      req_size   = (($urandom % 10) == 0) ? 2'($urandom) : 2'b10;
      req_wdata  = (req_addr == 6'h00) ? 32'(($urandom % 4) != 0) : $urandom;
    end
    @(negedge clk); req_valid = 0;
    repeat (3) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule